// File: doc/BRIEF.md
# Bus Trigger Unit with Arming

This block sits beside a processor core and inspects every instruction-fetch and data-access cycle against a small bank of programmable comparators. When a comparator matches, it raises the one action it was set up for: halting the core, pulsing a pin for external instruments such as a logic analyzer, starting or stopping trace collection, capturing one trace sample, or arming another comparator. The trace store and the host link sit outside the block; it only produces the action pulses and a trace-running level.

Two refinements make the comparators more useful than plain equality. An even-numbered comparator can borrow its odd neighbour's value as an inclusive upper bound, turning the pair into a single range trigger. A comparator can also be marked as needing arming, in which case it stays silent until some other comparator with the arm action has fired on an earlier cycle, giving an "event A, then event B" sequence. The arm state persists until the host clears it.

Each comparator carries a small arm state machine with states `ARM_IDLE` and `ARM_SET`; the transition `ARM_IDLE -> ARM_SET` is taken on an arm request without a disarm, and `ARM_SET -> ARM_IDLE` on a disarm. A trace-gate state machine has states `TR_STOP` and `TR_RUN`; `TR_STOP -> TR_RUN` on a start hit without a stop hit, and `TR_RUN -> TR_STOP` on any stop hit.

Top module: `bus_trig_unit`

## Requirements
- R1: A write with `cfg_we` high loads comparator `cfg_idx` with `cfg_value` and the control word `cfg_ctrl`, whose bits are: bit 0 enable, bit 1 bus select (1 = data bus, 0 = instruction bus), bit 2 field select (1 = data word, 0 = address), bit 3 range pairing, bit 4 needs arming, bits 7:5 action code, bits above 7 the arm target index; a comparator whose enable bit is 0 never fires.
- R2: An instruction-bus comparator fires when `ibus_valid` is high and `ibus_addr` equals its value (the field bit is ignored), and its action output is a pulse one clock wide, registered on the clock edge that samples the bus cycle.
- R3: A data-bus comparator fires when `dbus_valid` is high and the selected field (`dbus_addr` when field bit is 0, `dbus_data` when 1) equals its value.
- R4: Action codes map as 0 to `halt_o`, 1 to `ext_trig_o`, 2 to `trace_on_o`, 3 to `trace_off_o`, 4 to `sample_o`, 5 to arming the target comparator with no output pulse, and 6 and 7 to no effect.
- R5: The sample action (code 4) on an instruction-bus comparator produces no `sample_o` pulse.
- R6: An even comparator with the range bit set fires when its selected value x satisfies lower <= x <= upper, lower being its own value and upper the value of the next odd comparator, using the even comparator's bus, field and action; the odd partner then never fires on its own.
- R7: A comparator with the needs-arming bit is silent until a comparator with action 5 naming it as target has fired; the arming counts from the following bus cycle, not the one in which it happens.
- R8: The arm state persists across later cycles until `cfg_disarm` is high for one clock, which clears every comparator's arm state; a disarm in the same cycle as an arm hit leaves the target unarmed.
- R9: `trace_run_o` is low after reset, goes high after a start hit, goes low after a stop hit, and goes low when start and stop hits fall in the same cycle, while both pulses are still emitted.
- R10: Reset (`rst` high, synchronous) disables all comparators, clears all arm states, stops trace and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Comparator index for the write |
| cfg_ctrl | input | 8+IW | Control word for the write |
| cfg_value | input | W | Compare value for the write |
| cfg_disarm | input | 1 | Clears the arm state of every comparator |
| ibus_valid | input | 1 | Instruction bus cycle strobe |
| ibus_addr | input | W | Instruction fetch address |
| dbus_valid | input | 1 | Data bus cycle strobe |
| dbus_addr | input | W | Data access address |
| dbus_data | input | W | Data access word |
| halt_o | output | 1 | Halt request pulse |
| ext_trig_o | output | 1 | External trigger pulse |
| trace_on_o | output | 1 | Trace start pulse |
| trace_off_o | output | 1 | Trace stop pulse |
| sample_o | output | 1 | Single trace sample pulse |
| trace_run_o | output | 1 | Trace gate level |

## Verification
Two functions can collide in one clock: an arming comparator and the comparator it arms can both see a match in the same bus cycle, and the trace start and stop actions can both be hit at once. The bench provokes the first by presenting an instruction fetch that hits the arming comparator together with a data access that matches the armed one, and judges that no pulse appears then but one does on the next matching cycle. It provokes the second with a data access whose address hits a start comparator while its data word hits a stop comparator, expecting both pulses and a stopped trace gate.

// File: rtl/btu_pkg.sv
package btu_pkg;

    typedef enum logic [2:0] {
        ACT_BREAK  = 3'd0,
        ACT_EXT    = 3'd1,
        ACT_TON    = 3'd2,
        ACT_TOFF   = 3'd3,
        ACT_SAMPLE = 3'd4,
        ACT_ARM    = 3'd5,
        ACT_RSV6   = 3'd6,
        ACT_RSV7   = 3'd7
    } act_e;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_SET  = 1'b1
    } arm_st_e;

    typedef enum logic {
        TR_STOP = 1'b0,
        TR_RUN  = 1'b1
    } tr_st_e;

    localparam int CTL_EN   = 0;
    localparam int CTL_BUS  = 1;
    localparam int CTL_FLD  = 2;
    localparam int CTL_RNG  = 3;
    localparam int CTL_NARM = 4;
    localparam int CTL_ACT  = 5;
    localparam int CTL_TGT  = 8;

endpackage

// File: rtl/btu_cfg_regs.sv
module btu_cfg_regs
    import btu_pkg::*;
#(
    parameter int NUM_TRIG = 4,
    parameter int W        = 16,
    localparam int IW      = $clog2(NUM_TRIG),
    localparam int CW      = CTL_TGT + IW
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [IW-1:0]                cfg_idx,
    input  logic [CW-1:0]                cfg_ctrl,
    input  logic [W-1:0]                 cfg_value,
    output logic [NUM_TRIG-1:0]          en_q,
    output logic [NUM_TRIG-1:0]          bus_q,
    output logic [NUM_TRIG-1:0]          fld_q,
    output logic [NUM_TRIG-1:0]          rng_q,
    output logic [NUM_TRIG-1:0]          narm_q,
    output logic [NUM_TRIG-1:0][2:0]     act_q,
    output logic [NUM_TRIG-1:0][IW-1:0]  tgt_q,
    output logic [NUM_TRIG-1:0][W-1:0]   val_q
);

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[g]   <= 1'b0;
                bus_q[g]  <= 1'b0;
                fld_q[g]  <= 1'b0;
                rng_q[g]  <= 1'b0;
                narm_q[g] <= 1'b0;
                act_q[g]  <= 3'd0;
                tgt_q[g]  <= '0;
                val_q[g]  <= '0;
            end else if (cfg_we && cfg_idx == IW'(g)) begin
                en_q[g]   <= cfg_ctrl[CTL_EN];
                bus_q[g]  <= cfg_ctrl[CTL_BUS];
                fld_q[g]  <= cfg_ctrl[CTL_FLD];
                rng_q[g]  <= cfg_ctrl[CTL_RNG];
                narm_q[g] <= cfg_ctrl[CTL_NARM];
                act_q[g]  <= cfg_ctrl[CTL_ACT +: 3];
                tgt_q[g]  <= cfg_ctrl[CTL_TGT +: IW];
                val_q[g]  <= cfg_value;
            end
        end
    end

endmodule

// File: rtl/btu_cmp.sv
module btu_cmp #(
    parameter int W      = 16,
    parameter bit HAS_HI = 1'b1,
    parameter bit IS_ODD = 1'b0
) (
    input  logic         en,
    input  logic         bus,
    input  logic         fld,
    input  logic         rng,
    input  logic         narm,
    input  logic         armed,
    input  logic         partner_rng,
    input  logic [W-1:0] lo_val,
    input  logic [W-1:0] hi_val,
    input  logic         ibus_valid,
    input  logic [W-1:0] ibus_addr,
    input  logic         dbus_valid,
    input  logic [W-1:0] dbus_addr,
    input  logic [W-1:0] dbus_data,
    output logic         hit
);

    logic [W-1:0] probe;
    logic         live;
    logic         cmp;
    logic         muted;

    always_comb begin
        if (bus) begin
            probe = fld ? dbus_data : dbus_addr;
            live  = dbus_valid;
        end else begin
            probe = ibus_addr;
            live  = ibus_valid;
        end

        if (HAS_HI && rng) begin
            cmp = (probe >= lo_val) && (probe <= hi_val);
        end else begin
            cmp = (probe == lo_val);
        end

        muted = IS_ODD && partner_rng;
        hit   = en && live && cmp && !muted && (!narm || armed);
    end

endmodule

// File: rtl/btu_arm_fsm.sv
module btu_arm_fsm
    import btu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm_req,
    input  logic disarm,
    output logic armed
);

    arm_st_e st_q;
    arm_st_e st_nx;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ARM_IDLE: if (arm_req && !disarm) st_nx = ARM_SET;
            ARM_SET:  if (disarm)             st_nx = ARM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ARM_IDLE;
        else     st_q <= st_nx;
    end

    always_comb armed = (st_q == ARM_SET);

endmodule

// File: rtl/btu_act.sv
module btu_act
    import btu_pkg::*;
#(
    parameter int NUM_TRIG = 4,
    localparam int IW      = $clog2(NUM_TRIG)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_TRIG-1:0]          hit,
    input  logic [NUM_TRIG-1:0]          bus,
    input  logic [NUM_TRIG-1:0][2:0]     act,
    input  logic [NUM_TRIG-1:0][IW-1:0]  tgt,
    output logic [NUM_TRIG-1:0]          arm_req,
    output logic                         halt_o,
    output logic                         ext_trig_o,
    output logic                         trace_on_o,
    output logic                         trace_off_o,
    output logic                         sample_o,
    output logic                         trace_run_o
);

    logic   want_halt, want_ext, want_on, want_off, want_smp;
    tr_st_e tr_q;
    tr_st_e tr_nx;

    always_comb begin
        want_halt = 1'b0;
        want_ext  = 1'b0;
        want_on   = 1'b0;
        want_off  = 1'b0;
        want_smp  = 1'b0;
        arm_req   = '0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (hit[i]) begin
                case (act_e'(act[i]))
                    ACT_BREAK:  want_halt = 1'b1;
                    ACT_EXT:    want_ext  = 1'b1;
                    ACT_TON:    want_on   = 1'b1;
                    ACT_TOFF:   want_off  = 1'b1;
                    ACT_SAMPLE: if (bus[i]) want_smp = 1'b1;
                    ACT_ARM:    arm_req[tgt[i]] = 1'b1;
                    default:    ;
                endcase
            end
        end
    end

    always_comb begin
        tr_nx = tr_q;
        unique case (tr_q)
            TR_STOP: if (want_on && !want_off) tr_nx = TR_RUN;
            TR_RUN:  if (want_off)             tr_nx = TR_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) tr_q <= TR_STOP;
        else     tr_q <= tr_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_o      <= 1'b0;
            ext_trig_o  <= 1'b0;
            trace_on_o  <= 1'b0;
            trace_off_o <= 1'b0;
            sample_o    <= 1'b0;
        end else begin
            halt_o      <= want_halt;
            ext_trig_o  <= want_ext;
            trace_on_o  <= want_on;
            trace_off_o <= want_off;
            sample_o    <= want_smp;
        end
    end

    always_comb trace_run_o = (tr_q == TR_RUN);

endmodule

// File: rtl/bus_trig_unit.sv
module bus_trig_unit
    import btu_pkg::*;
#(
    parameter int NUM_TRIG = 4,
    parameter int W        = 16,
    localparam int IW      = $clog2(NUM_TRIG),
    localparam int CW      = CTL_TGT + IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [CW-1:0] cfg_ctrl,
    input  logic [W-1:0]  cfg_value,
    input  logic          cfg_disarm,
    input  logic          ibus_valid,
    input  logic [W-1:0]  ibus_addr,
    input  logic          dbus_valid,
    input  logic [W-1:0]  dbus_addr,
    input  logic [W-1:0]  dbus_data,
    output logic          halt_o,
    output logic          ext_trig_o,
    output logic          trace_on_o,
    output logic          trace_off_o,
    output logic          sample_o,
    output logic          trace_run_o
);

    logic [NUM_TRIG-1:0]         en_q, bus_q, fld_q, rng_q, narm_q;
    logic [NUM_TRIG-1:0][2:0]    act_q;
    logic [NUM_TRIG-1:0][IW-1:0] tgt_q;
    logic [NUM_TRIG-1:0][W-1:0]  val_q;
    logic [NUM_TRIG-1:0]         hit_vec;
    logic [NUM_TRIG-1:0]         arm_req_vec;
    logic [NUM_TRIG-1:0]         armed_vec;

    btu_cfg_regs #(.NUM_TRIG(NUM_TRIG), .W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_ctrl  (cfg_ctrl),
        .cfg_value (cfg_value),
        .en_q      (en_q),
        .bus_q     (bus_q),
        .fld_q     (fld_q),
        .rng_q     (rng_q),
        .narm_q    (narm_q),
        .act_q     (act_q),
        .tgt_q     (tgt_q),
        .val_q     (val_q)
    );

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
        localparam bit ODD    = (g % 2) == 1;
        localparam bit HAS_HI = !ODD && (g + 1 < NUM_TRIG);
        logic [W-1:0] hi_w;
        logic         prng_w;

        if (HAS_HI) begin : g_hi
            assign hi_w   = val_q[g+1];
            assign prng_w = 1'b0;
        end else if (ODD) begin : g_odd
            assign hi_w   = val_q[g];
            assign prng_w = rng_q[g-1];
        end else begin : g_last
            assign hi_w   = val_q[g];
            assign prng_w = 1'b0;
        end

        btu_cmp #(.W(W), .HAS_HI(HAS_HI), .IS_ODD(ODD)) u_cmp (
            .en          (en_q[g]),
            .bus         (bus_q[g]),
            .fld         (fld_q[g]),
            .rng         (rng_q[g]),
            .narm        (narm_q[g]),
            .armed       (armed_vec[g]),
            .partner_rng (prng_w),
            .lo_val      (val_q[g]),
            .hi_val      (hi_w),
            .ibus_valid  (ibus_valid),
            .ibus_addr   (ibus_addr),
            .dbus_valid  (dbus_valid),
            .dbus_addr   (dbus_addr),
            .dbus_data   (dbus_data),
            .hit         (hit_vec[g])
        );

        btu_arm_fsm u_arm (
            .clk     (clk),
            .rst     (rst),
            .arm_req (arm_req_vec[g]),
            .disarm  (cfg_disarm),
            .armed   (armed_vec[g])
        );
    end

    btu_act #(.NUM_TRIG(NUM_TRIG)) u_act (
        .clk         (clk),
        .rst         (rst),
        .hit         (hit_vec),
        .bus         (bus_q),
        .act         (act_q),
        .tgt         (tgt_q),
        .arm_req     (arm_req_vec),
        .halt_o      (halt_o),
        .ext_trig_o  (ext_trig_o),
        .trace_on_o  (trace_on_o),
        .trace_off_o (trace_off_o),
        .sample_o    (sample_o),
        .trace_run_o (trace_run_o)
    );

endmodule

// File: rtl/bus_trig_unit_chk.sv
module bus_trig_unit_chk #(
    parameter int NUM_TRIG = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_disarm,
    input logic                ibus_valid,
    input logic                dbus_valid,
    input logic                halt_o,
    input logic                ext_trig_o,
    input logic                trace_on_o,
    input logic                trace_off_o,
    input logic                sample_o,
    input logic                trace_run_o,
    input logic [NUM_TRIG-1:0] armed
);

    // R5: a sample pulse can only follow a data bus cycle
    a_r5_sample_from_dbus: assert property (@(posedge clk) disable iff (rst)
        sample_o |-> $past(dbus_valid));

    // R2: every action pulse follows some bus cycle on the previous clock
    a_r2_pulse_after_bus: assert property (@(posedge clk) disable iff (rst)
        (halt_o || ext_trig_o || trace_on_o || trace_off_o || sample_o)
        |-> $past(ibus_valid || dbus_valid));

    // R9: a stop pulse always leaves the trace gate stopped
    a_r9_stop_wins: assert property (@(posedge clk) disable iff (rst)
        trace_off_o |-> !trace_run_o);

    // R9: a lone start pulse leaves the trace gate running
    a_r9_start_runs: assert property (@(posedge clk) disable iff (rst)
        (trace_on_o && !trace_off_o) |-> trace_run_o);

    // R8: a disarm clears every arm state on the next clock
    a_r8_disarm_clears: assert property (@(posedge clk) disable iff (rst)
        cfg_disarm |=> (armed == '0));

endmodule

bind bus_trig_unit bus_trig_unit_chk #(.NUM_TRIG(NUM_TRIG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_disarm  (cfg_disarm),
    .ibus_valid  (ibus_valid),
    .dbus_valid  (dbus_valid),
    .halt_o      (halt_o),
    .ext_trig_o  (ext_trig_o),
    .trace_on_o  (trace_on_o),
    .trace_off_o (trace_off_o),
    .sample_o    (sample_o),
    .trace_run_o (trace_run_o),
    .armed       (armed_vec)
);

// File: tb/bus_trig_unit_bench.sv
`timescale 1ns/1ps
module bus_trig_unit_bench;

    localparam int N  = 4;
    localparam int W  = 8;
    localparam int IW = 2;
    localparam int CW = 8 + IW;

    localparam logic [5:0] M_RUN  = 6'b100000;
    localparam logic [5:0] M_HALT = 6'b010000;
    localparam logic [5:0] M_EXT  = 6'b001000;
    localparam logic [5:0] M_TON  = 6'b000100;
    localparam logic [5:0] M_TOFF = 6'b000010;
    localparam logic [5:0] M_SMP  = 6'b000001;
    localparam logic [5:0] M_PUL  = 6'b011111;
    localparam logic [5:0] M_ALL  = 6'b111111;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [CW-1:0] cfg_ctrl = '0;
    logic [W-1:0]  cfg_value = '0;
    logic          cfg_disarm = 1'b0;
    logic          ibus_valid = 1'b0;
    logic [W-1:0]  ibus_addr = '0;
    logic          dbus_valid = 1'b0;
    logic [W-1:0]  dbus_addr = '0;
    logic [W-1:0]  dbus_data = '0;
    logic          halt_o, ext_trig_o, trace_on_o, trace_off_o, sample_o, trace_run_o;

    int   n_total = 0;
    int   n_fail  = 0;
    int   n_cyc   = 0;
    logic [5:0] obs;

    always #10 clk = ~clk;

    bus_trig_unit #(.NUM_TRIG(N), .W(W)) u_bus_trig_unit (
        .clk, .rst, .cfg_we, .cfg_idx, .cfg_ctrl, .cfg_value, .cfg_disarm,
        .ibus_valid, .ibus_addr, .dbus_valid, .dbus_addr, .dbus_data,
        .halt_o, .ext_trig_o, .trace_on_o, .trace_off_o, .sample_o, .trace_run_o
    );

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc == 150000) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", n_cyc);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    function automatic logic [CW-1:0] mk(input logic en, input logic bus, input logic fld,
                                        input logic rng, input logic narm,
                                        input logic [2:0] act, input logic [IW-1:0] tgt);
        return {tgt, act, narm, rng, fld, bus, en};
    endfunction

    function automatic logic [5:0] act_mask(input int code);
        case (code)
            0: return M_HALT;
            1: return M_EXT;
            2: return M_TON;
            3: return M_TOFF;
            4: return M_SMP;
            default: return 6'b0;
        endcase
    endfunction

    task automatic wcfg(input int idx, input logic [CW-1:0] ctl, input logic [W-1:0] val);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_ctrl = ctl; cfg_value = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clr_all();
        for (int i = 0; i < N; i++) wcfg(i, '0, '0);
    endtask

    // drive one bus cycle at a falling edge, capture outputs one edge later
    task automatic step(input logic iv, input logic [W-1:0] ia, input logic dv,
                        input logic [W-1:0] da, input logic [W-1:0] dd, input logic dis);
        ibus_valid = iv; ibus_addr = ia;
        dbus_valid = dv; dbus_addr = da; dbus_data = dd;
        cfg_disarm = dis;
        @(negedge clk);
        obs = {trace_run_o, halt_o, ext_trig_o, trace_on_o, trace_off_o, sample_o};
        ibus_valid = 1'b0; dbus_valid = 1'b0; cfg_disarm = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [5:0] got,
                       input logic [5:0] exp, input logic [5:0] mask);
        n_total++;
        if ((got & mask) !== (exp & mask)) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got & mask, exp & mask);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: quiet after reset, default config matches nothing
        chk("R10 reset outputs", {trace_run_o, halt_o, ext_trig_o, trace_on_o, trace_off_o, sample_o}, 6'b0, M_ALL);
        step(1'b1, 8'h00, 1'b1, 8'h00, 8'h00, 1'b0);
        chk("R10 R1 disabled after reset", obs, 6'b0, M_ALL);

        // R2: instruction address equality sweep, break action
        wcfg(0, mk(1, 0, 0, 0, 0, 3'd0, 0), 8'h5A);
        for (int a = 0; a < 256; a++) begin
            step(1'b1, W'(a), 1'b0, 8'h00, 8'h00, 1'b0);
            chk("R2 ibus sweep", obs, (a == 8'h5A) ? M_HALT : 6'b0, M_PUL);
        end
        step(1'b1, 8'h5A, 1'b0, 8'h00, 8'h00, 1'b0);
        step(1'b0, 8'h5A, 1'b0, 8'h00, 8'h00, 1'b0);
        chk("R2 single-cycle pulse", obs, 6'b0, M_PUL);
        wcfg(0, mk(1, 0, 1, 0, 0, 3'd0, 0), 8'h5A);
        step(1'b1, 8'h5A, 1'b0, 8'h00, 8'h00, 1'b0);
        chk("R2 field bit ignored on ibus", obs, M_HALT, M_PUL);
        step(1'b0, 8'h00, 1'b1, 8'h5A, 8'h5A, 1'b0);
        chk("R2 ibus trigger ignores dbus", obs, 6'b0, M_PUL);

        // R1: disabling the comparator silences it
        wcfg(0, mk(0, 0, 0, 0, 0, 3'd0, 0), 8'h5A);
        step(1'b1, 8'h5A, 1'b0, 8'h00, 8'h00, 1'b0);
        chk("R1 disabled comparator", obs, 6'b0, M_PUL);

        // R3: data bus field selection
        clr_all();
        wcfg(1, mk(1, 1, 1, 0, 0, 3'd1, 0), 8'h33);
        step(1'b0, 8'h00, 1'b1, 8'h33, 8'h00, 1'b0);
        chk("R3 data field ignores address", obs, 6'b0, M_PUL);
        step(1'b0, 8'h00, 1'b1, 8'h00, 8'h33, 1'b0);
        chk("R3 data field match", obs, M_EXT, M_PUL);
        wcfg(1, mk(1, 1, 0, 0, 0, 3'd1, 0), 8'h33);
        step(1'b0, 8'h00, 1'b1, 8'h33, 8'h00, 1'b0);
        chk("R3 address field match", obs, M_EXT, M_PUL);
        step(1'b1, 8'h33, 1'b0, 8'h33, 8'h33, 1'b0);
        chk("R3 dbus trigger ignores ibus", obs, 6'b0, M_PUL);

        // R4: every action code on a data-address comparator
        clr_all();
        for (int k = 0; k < 8; k++) begin
            wcfg(0, mk(1, 1, 0, 0, 0, 3'(k), 0), 8'h10);
            step(1'b0, 8'h00, 1'b1, 8'h10, 8'h00, 1'b0);
            chk("R4 action code", obs, act_mask(k), M_PUL);
        end

        // R5: sample on an instruction-bus comparator does nothing
        wcfg(0, mk(1, 0, 0, 0, 0, 3'd4, 0), 8'h20);
        step(1'b1, 8'h20, 1'b0, 8'h00, 8'h00, 1'b0);
        chk("R5 sample blocked on ibus", obs, 6'b0, M_PUL);
        wcfg(0, mk(1, 1, 0, 0, 0, 3'd4, 0), 8'h20);
        step(1'b0, 8'h00, 1'b1, 8'h20, 8'h00, 1'b0);
        chk("R5 sample allowed on dbus", obs, M_SMP, M_PUL);

        // R6: inclusive range sweep with enabled odd partner
        clr_all();
        wcfg(0, mk(1, 1, 0, 1, 0, 3'd1, 0), 8'h30);
        wcfg(1, mk(1, 1, 0, 0, 0, 3'd0, 0), 8'h50);
        for (int a = 0; a < 256; a++) begin
            step(1'b0, 8'h00, 1'b1, W'(a), 8'h00, 1'b0);
            chk("R6 range sweep", obs, (a >= 8'h30 && a <= 8'h50) ? M_EXT : 6'b0, M_PUL);
        end
        wcfg(2, mk(1, 1, 1, 1, 0, 3'd4, 0), 8'hF0);
        wcfg(3, mk(0, 0, 0, 0, 0, 3'd0, 0), 8'hFF);
        step(1'b0, 8'h00, 1'b1, 8'h00, 8'hFF, 1'b0);
        chk("R6 data range top edge", obs, M_SMP, M_PUL);
        step(1'b0, 8'h00, 1'b1, 8'h00, 8'hEF, 1'b0);
        chk("R6 data range below", obs, 6'b0, M_PUL);

        // R7: A-then-B sequence, with a same-cycle collision
        clr_all();
        wcfg(2, mk(1, 1, 0, 0, 1, 3'd1, 0), 8'h77);
        wcfg(0, mk(1, 0, 0, 0, 0, 3'd5, 2), 8'h11);
        step(1'b0, 8'h00, 1'b1, 8'h77, 8'h00, 1'b0);
        chk("R7 unarmed is silent", obs, 6'b0, M_PUL);
        step(1'b1, 8'h11, 1'b1, 8'h77, 8'h00, 1'b0);
        chk("R7 arm same cycle no fire", obs, 6'b0, M_PUL);
        step(1'b0, 8'h00, 1'b1, 8'h77, 8'h00, 1'b0);
        chk("R7 armed fires", obs, M_EXT, M_PUL);
        step(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        step(1'b0, 8'h00, 1'b1, 8'h77, 8'h00, 1'b0);
        chk("R8 arm persists", obs, M_EXT, M_PUL);

        // R8: disarm and disarm-vs-arm collision
        step(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
        step(1'b0, 8'h00, 1'b1, 8'h77, 8'h00, 1'b0);
        chk("R8 disarm silences", obs, 6'b0, M_PUL);
        step(1'b1, 8'h11, 1'b0, 8'h00, 8'h00, 1'b1);
        step(1'b0, 8'h00, 1'b1, 8'h77, 8'h00, 1'b0);
        chk("R8 disarm beats arm", obs, 6'b0, M_PUL);
        step(1'b1, 8'h11, 1'b0, 8'h00, 8'h00, 1'b0);
        step(1'b0, 8'h00, 1'b1, 8'h77, 8'h00, 1'b0);
        chk("R8 rearm by event", obs, M_EXT, M_PUL);

        // R9: trace gate
        clr_all();
        wcfg(0, mk(1, 1, 0, 0, 0, 3'd2, 0), 8'h40);
        wcfg(1, mk(1, 1, 0, 0, 0, 3'd3, 0), 8'h41);
        wcfg(3, mk(1, 1, 1, 0, 0, 3'd3, 0), 8'h99);
        step(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        chk("R9 gate stopped", obs, 6'b0, M_RUN);
        step(1'b0, 8'h00, 1'b1, 8'h40, 8'h00, 1'b0);
        chk("R9 start", obs, M_RUN | M_TON, M_ALL);
        step(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        chk("R9 stays running", obs, M_RUN, M_ALL);
        step(1'b0, 8'h00, 1'b1, 8'h41, 8'h00, 1'b0);
        chk("R9 stop", obs, M_TOFF, M_ALL);
        step(1'b0, 8'h00, 1'b1, 8'h40, 8'h00, 1'b0);
        step(1'b0, 8'h00, 1'b1, 8'h40, 8'h99, 1'b0);
        chk("R9 start and stop together", obs, M_TON | M_TOFF, M_ALL);

        // R10: reset mid-run clears arm state and gate
        wcfg(2, mk(1, 1, 0, 0, 1, 3'd1, 0), 8'h77);
        wcfg(1, mk(1, 0, 0, 0, 0, 3'd5, 2), 8'h11);
        step(1'b1, 8'h11, 1'b1, 8'h40, 8'h00, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset clears gate", {trace_run_o, halt_o, ext_trig_o, trace_on_o, trace_off_o, sample_o}, 6'b0, M_ALL);
        wcfg(2, mk(1, 1, 0, 0, 1, 3'd1, 0), 8'h77);
        step(1'b0, 8'h00, 1'b1, 8'h77, 8'h00, 1'b0);
        chk("R10 reset clears arm", obs, 6'b0, M_PUL);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule